// File: doc/BRIEF.md
# Shadow Memory Region Router

This block classifies every memory cycle that touches the legacy upper-memory window (C0000h to FFFFFh) or the highest megabyte of a 32-bit address space. For each accepted cycle it decides whether the access is served by local DRAM or passed to the ISA expansion bus. It also decides whether the boot ROM chip-select fires and whether the cycle hits a write-protected shadow copy. Seven segments are handled: four 16KB slices of the C block and the whole D, E and F blocks.

Software programs four byte registers through an index/data pair: a shadow read mask, a shadow write mask, a ROM-select mask and a mask used only in system management mode. While the management-mode input is high, that last mask stands in for the D, E and F bits of both shadow masks. The route is registered one clock after the cycle strobe, so the surrounding memory controller consumes a steady decision on the following cycle.

Top module: `shadow_router`

## Requirements
- R1: After reset the read mask (index 19h) and write mask (index 1Ah) read 00h, the ROM-select mask (index 1Bh) reads 60h and the management-mode mask (index 1Ch) reads 00h.
- R2: With `cfg_sel`=0 a write loads the index; with `cfg_sel`=1 a write loads the indexed register and `cfg_rdata` returns it. Other indexes read 00h and writes to them change nothing. Bit 7 of the read and write masks and bits 3 and 7 of the management mask always read 0.
- R3: Mask bits 0..6 select segments C0000-C3FFF, C4000-C7FFF, C8000-CBFFF, CC000-CFFFF, D0000-DFFFF, E0000-EFFFF and F0000-FFFFF in that order. Only addresses with bits 31:20 equal to 0 hit a segment.
- R4: A read of a segment goes to DRAM when the effective read bit is 1 and to ISA when it is 0.
- R5: A write of a segment goes to DRAM when the effective write bit is 1 and to ISA when it is 0.
- R6: A segment cycle routed to ISA drives `rom_cs_n` low when its ROM-select bit is 1, on reads always and on writes only when ROM-select bit 7 is 1.
- R7: `rom_cs_n` stays high for every cycle routed to DRAM.
- R8: While `smm_mode` is 1, the management mask bits 0..2 replace the read bits for D, E and F, and its bits 4..6 replace the write bits for D, E and F. The C segments are unaffected.
- R9: Any cycle with address bits 31:20 equal to FFFh goes to ISA with `rom_cs_n` low and `wprot_n` high, whatever the masks hold.
- R10: Any other cycle outside the seven segments gives `decoded`=0, `dram_sel`=1 and `rom_cs_n`=1.
- R11: Outputs reflect the cycle presented at the previous clock edge with `cyc_valid` high. Exactly one of `dram_sel` and `isa_sel` is then 1. After an edge without `cyc_valid`, `out_valid`, `dram_sel`, `isa_sel` and `decoded` are 0 and `rom_cs_n` and `wprot_n` are 1.
- R12: `wprot_n` goes low for a segment write whose effective read bit is 1 and effective write bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | 0 selects the index register, 1 the data register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Index (cfg_sel=0) or indexed register (cfg_sel=1) |
| cyc_valid | input | 1 | Memory cycle present |
| cyc_addr | input | AW | Cycle address |
| cyc_write | input | 1 | 1 for a write cycle |
| smm_mode | input | 1 | System management mode active |
| out_valid | output | 1 | Route below is for a cycle |
| dram_sel | output | 1 | Cycle goes to local DRAM |
| isa_sel | output | 1 | Cycle goes to ISA |
| rom_cs_n | output | 1 | Boot ROM chip-select, active low |
| wprot_n | output | 1 | Write to a protected shadow, active low |
| decoded | output | 1 | Cycle fell in a segment or the top megabyte |

## Verification
The assertions assume `cyc_addr`, `cyc_write` and `smm_mode` are stable at the sampling edge along with `cyc_valid`, and that a configuration write and a routed cycle in the same edge may be ordered freely because the route uses the register values from before that edge. The stimulus changes inputs only on the falling edge, and the reference model in the bench evaluates each cycle against the mask state before applying that edge's configuration write. Addresses are drawn from segment edges, segment interiors, the top megabyte and unrelated regions, so every branch the properties check is reached.

// File: rtl/shadow_router.sv
module shadow_router #(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter logic [7:0] IDX_RD  = 8'h19,
  parameter logic [7:0] IDX_WR  = 8'h1A,
  parameter logic [7:0] IDX_ROM = 8'h1B,
  parameter logic [7:0] IDX_SMM = 8'h1C,
  parameter logic [7:0] ROM_RST = 8'h60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic          cyc_write,
  input  logic          smm_mode,
  output logic          out_valid,
  output logic          dram_sel,
  output logic          isa_sel,
  output logic          rom_cs_n,
  output logic          wprot_n,
  output logic          decoded
);
  localparam int NSEG = 7;
  localparam int NQ = 4;
  localparam logic [DW-1:0] SHAD_MASK = DW'(8'h7F);
  localparam logic [DW-1:0] SMM_MASK  = DW'(8'h77);

  logic [DW-1:0] idx_q, rd_q, wr_q, rom_q, smm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      rom_q <= DW'(ROM_RST);
      smm_q <= '0;
    end else if (cfg_we) begin
      if (!cfg_sel) idx_q <= cfg_wdata;
      else begin
        if (idx_q == DW'(IDX_RD))  rd_q  <= cfg_wdata & SHAD_MASK;
        if (idx_q == DW'(IDX_WR))  wr_q  <= cfg_wdata & SHAD_MASK;
        if (idx_q == DW'(IDX_ROM)) rom_q <= cfg_wdata;
        if (idx_q == DW'(IDX_SMM)) smm_q <= cfg_wdata & SMM_MASK;
      end
    end
  end

  always_comb begin
    if (!cfg_sel) cfg_rdata = idx_q;
    else if (idx_q == DW'(IDX_RD))  cfg_rdata = rd_q;
    else if (idx_q == DW'(IDX_WR))  cfg_rdata = wr_q;
    else if (idx_q == DW'(IDX_ROM)) cfg_rdata = rom_q;
    else if (idx_q == DW'(IDX_SMM)) cfg_rdata = smm_q;
    else cfg_rdata = '0;
  end

  wire low_mb = (cyc_addr[AW-1:20] == '0);
  wire top_mb = &cyc_addr[AW-1:AW-12];
  wire [3:0] blk = cyc_addr[19:16];

  logic [NSEG-1:0] seg_hot;
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    if (i < NQ) begin : g_q
      assign seg_hot[i] = low_mb && blk == 4'hC && cyc_addr[15:14] == 2'(i);
    end else begin : g_b
      assign seg_hot[i] = low_mb && blk == 4'(4'hD + i - NQ);
    end
  end

  wire [NSEG-1:0] rd_eff = {smm_mode ? smm_q[2:0] : rd_q[6:4], rd_q[3:0]};
  wire [NSEG-1:0] wr_eff = {smm_mode ? smm_q[6:4] : wr_q[6:4], wr_q[3:0]};
  wire seg_hit = |seg_hot;
  wire to_dram = |(seg_hot & (cyc_write ? wr_eff : rd_eff));
  wire rom_hit = |(seg_hot & rom_q[NSEG-1:0]) && (!cyc_write || rom_q[7]);
  wire prot    = cyc_write && |(seg_hot & rd_eff & ~wr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dram_sel  <= 1'b0;
      isa_sel   <= 1'b0;
      rom_cs_n  <= 1'b1;
      wprot_n   <= 1'b1;
      decoded   <= 1'b0;
    end else if (!cyc_valid) begin
      out_valid <= 1'b0;
      dram_sel  <= 1'b0;
      isa_sel   <= 1'b0;
      rom_cs_n  <= 1'b1;
      wprot_n   <= 1'b1;
      decoded   <= 1'b0;
    end else if (top_mb) begin
      out_valid <= 1'b1;
      dram_sel  <= 1'b0;
      isa_sel   <= 1'b1;
      rom_cs_n  <= 1'b0;
      wprot_n   <= 1'b1;
      decoded   <= 1'b1;
    end else if (seg_hit) begin
      out_valid <= 1'b1;
      dram_sel  <= to_dram;
      isa_sel   <= !to_dram;
      rom_cs_n  <= !(rom_hit && !to_dram);
      wprot_n   <= !prot;
      decoded   <= 1'b1;
    end else begin
      out_valid <= 1'b1;
      dram_sel  <= 1'b1;
      isa_sel   <= 1'b0;
      rom_cs_n  <= 1'b1;
      wprot_n   <= 1'b1;
      decoded   <= 1'b0;
    end
  end
endmodule

module shadow_router_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_valid,
  input logic [AW-1:0] cyc_addr,
  input logic          out_valid,
  input logic          dram_sel,
  input logic          isa_sel,
  input logic          rom_cs_n,
  input logic          wprot_n,
  input logic          decoded
);
  wire top_a = &cyc_addr[AW-1:AW-12];
  wire low_a = (cyc_addr[AW-1:20] == '0);

  a_r11_one_route: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (dram_sel ^ isa_sel));
  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!dram_sel && !isa_sel && rom_cs_n && wprot_n && !decoded));
  a_r11_follow: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> out_valid);
  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !out_valid);
  a_r7_dram_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
    dram_sel |-> rom_cs_n);
  a_r9_top_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && top_a) |=> (isa_sel && !rom_cs_n && wprot_n && decoded));
  a_r10_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !top_a && !low_a) |=> (!decoded && dram_sel && rom_cs_n));
  a_r12_prot_isa: assert property (@(posedge clk) disable iff (!rst_n)
    !wprot_n |-> (isa_sel && decoded));
endmodule

bind shadow_router shadow_router_chk #(.AW(AW)) u_chk (.*);

// File: tb/shadow_router_bench.sv
module shadow_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sel = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        cyc_valid = 1'b0, cyc_write = 1'b0, smm_mode = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        out_valid, dram_sel, isa_sel, rom_cs_n, wprot_n, decoded;

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] m_idx = 0, m_rd = 0, m_wr = 0, m_rom = 8'h60, m_smm = 0;

  always #10 clk = ~clk;

  shadow_router u_shadow_router (.*);

  function automatic logic [5:0] model(bit v, logic [31:0] a, bit w, bit s);
    int k;
    bit re, we_, dr, rs, wp;
    if (!v) return 6'b000110;
    if (a >= 32'hFFF0_0000) return 6'b101011;
    k = -1;
    if (a >= 32'hC0000 && a < 32'hD0000) k = int'((a - 32'hC0000) >> 14);
    else if (a >= 32'hD0000 && a < 32'h100000) k = 4 + int'((a - 32'hD0000) >> 16);
    if (k < 0) return 6'b110110;
    re  = (s && k >= 4) ? m_smm[k-4] : m_rd[k];
    we_ = (s && k >= 4) ? m_smm[k]   : m_wr[k];
    dr = w ? we_ : re;
    rs = m_rom[k] && (!w || m_rom[7]) && !dr;
    wp = w && re && !we_;
    return {1'b1, dr, !dr, !rs, !wp, 1'b1};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a, bit w, bit s,
                      bit csel, bit cwe, logic [7:0] cd, string req);
    logic [5:0] exp;
    cyc_valid = v; cyc_addr = a; cyc_write = w; smm_mode = s;
    cfg_sel = csel; cfg_we = cwe; cfg_wdata = cd;
    exp = model(v, a, w, s);
    if (cwe) begin
      if (!csel) m_idx = cd;
      else case (m_idx)
        8'h19: m_rd  = cd & 8'h7F;
        8'h1A: m_wr  = cd & 8'h7F;
        8'h1B: m_rom = cd;
        8'h1C: m_smm = cd & 8'h77;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    check(req, {2'b00, out_valid, dram_sel, isa_sel, rom_cs_n, wprot_n, decoded}, {2'b00, exp});
    cfg_we = 1'b0; cyc_valid = 1'b0;
  endtask

  task automatic wr_reg(logic [7:0] idx, logic [7:0] d);
    step(0, 0, 0, 0, 0, 1, idx, "R2");
    step(0, 0, 0, 0, 1, 1, d, "R2");
  endtask

  task automatic rd_reg(logic [7:0] idx, logic [7:0] exp, string req);
    step(0, 0, 0, 0, 0, 1, idx, req);
    cfg_sel = 1'b1;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  initial begin
    logic [31:0] segbase [7] = '{32'hC0000, 32'hC4000, 32'hC8000, 32'hCC000,
                                 32'hD0000, 32'hE0000, 32'hF0000};
    logic [31:0] segsz [7] = '{32'h4000, 32'h4000, 32'h4000, 32'h4000,
                               32'h10000, 32'h10000, 32'h10000};
    logic [7:0] pats [4][4] = '{'{8'h00, 8'h00, 8'h60, 8'h00},
                                '{8'h77, 8'h00, 8'h63, 8'h05},
                                '{8'h0F, 8'h70, 8'hFF, 8'h70},
                                '{8'hD5, 8'h2A, 8'hE3, 8'h52}};
    repeat (3) @(negedge clk);
    check("R11", {2'b00, out_valid, dram_sel, isa_sel, rom_cs_n, wprot_n, decoded}, 8'b00000110);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd_reg(8'h19, 8'h00, "R1");
    rd_reg(8'h1A, 8'h00, "R1");
    rd_reg(8'h1B, 8'h60, "R1");
    rd_reg(8'h1C, 8'h00, "R1");
    // R2 reserved bits and unclaimed index
    wr_reg(8'h19, 8'hFF); rd_reg(8'h19, 8'h7F, "R2");
    wr_reg(8'h1C, 8'hFF); rd_reg(8'h1C, 8'h77, "R2");
    wr_reg(8'h20, 8'hAB); rd_reg(8'h20, 8'h00, "R2");
    rd_reg(8'h1A, 8'h00, "R2");
    rd_reg(8'h1B, 8'h60, "R2");
    step(0, 0, 0, 0, 0, 1, 8'h1B, "R2");
    cfg_sel = 1'b0; #1; check("R2", cfg_rdata, 8'h1B);
    // R3 boundaries
    wr_reg(8'h19, 8'h02); wr_reg(8'h1C, 8'h00);
    step(1, 32'hC3FFF, 0, 0, 0, 0, 0, "R3");
    step(1, 32'hC4000, 0, 0, 0, 0, 0, "R3");
    step(1, 32'hC7FFF, 0, 0, 0, 0, 0, "R3");
    step(1, 32'h1C4000, 0, 0, 0, 0, 0, "R3");
    // R6 rom on writes only with bit 7
    wr_reg(8'h19, 8'h00); wr_reg(8'h1B, 8'h40);
    step(1, 32'hF1234, 1, 0, 0, 0, 0, "R6");
    step(1, 32'hF1234, 0, 0, 0, 0, 0, "R6");
    wr_reg(8'h1B, 8'hC0);
    step(1, 32'hF1234, 1, 0, 0, 0, 0, "R6");
    // R7 dram precedence
    wr_reg(8'h19, 8'h40);
    step(1, 32'hFFFF0, 0, 0, 0, 0, 0, "R7");
    // R12 write protect
    step(1, 32'hFFFF0, 1, 0, 0, 0, 0, "R12");
    // R9 top megabyte
    step(1, 32'hFFF0_0000, 0, 0, 0, 0, 0, "R9");
    step(1, 32'hFFFF_FFF0, 1, 1, 0, 0, 0, "R9");
    // R10 outside
    step(1, 32'h000B8000, 0, 0, 0, 0, 0, "R10");
    step(1, 32'h0FFF_0000, 1, 0, 0, 0, 0, "R10");
    step(1, 32'hFFE0_0000, 0, 0, 0, 0, 0, "R10");
    // config write and routed cycle on the same edge
    step(0, 0, 0, 0, 0, 1, 8'h19, "R2");
    step(1, 32'hF0000, 0, 0, 1, 1, 8'h00, "R11");
    step(1, 32'hF0000, 0, 0, 0, 0, 0, "R11");
    // sweep patterns
    for (int p = 0; p < 4; p++) begin
      wr_reg(8'h19, pats[p][0]); wr_reg(8'h1A, pats[p][1]);
      wr_reg(8'h1B, pats[p][2]); wr_reg(8'h1C, pats[p][3]);
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 7; k++)
          for (int w = 0; w < 2; w++) begin
            logic [31:0] a;
            a = segbase[k] + ((segsz[k] - 1) & (32'h1357 * (k + 3 * p + 1)));
            step(1, a, w[0], s[0], 0, 0, 0,
                 (s == 1 && k >= 4) ? "R8" : (w == 1 ? "R5" : "R4"));
            step(0, 0, 0, 0, 0, 0, 0, "R11");
          end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule